// File: doc/BRIEF.md
# Power-Management Event and SCI Controller

This block holds the power-management event state of a chipset: a sticky status register, a matching enable register, a control register and a free-running up-counting power-management timer. Three external event inputs (power button, real-time-clock alarm and global-lock release) and the timer's most-significant-bit transitions latch status bits. Software clears a status bit by writing a one to it.

The block raises a level-sensitive system control interrupt (SCI) whenever an enabled status bit among the four interrupt sources is pending, but only if the configured interrupt pin value is nonzero. It also emits a one-cycle timer-overflow indication when the timer's top bit flips while timer overflow monitoring is armed. Software reaches all registers through a byte-wide register port, one byte per access. Reads are combinational from the address and writes take effect at the clock edge.

Top module: `pm_event_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, status, enable, control and the timer all return to zero, and `sci` and `tmr_ovf` read low in the following cycle.
- R2: Byte addresses are: 0 status[7:0], 1 status[15:8], 2 enable[7:0], 3 enable[15:8], 4 control[7:0], 5 control[15:8], 6 upward the timer bytes least-significant first. Any other address reads zero. `reg_rdata` follows `reg_addr` in the same cycle.
- R3: Status bit positions are timer 0, global lock 5, power button 8 and RTC 10. A high event input at a clock edge sets its bit, and the bit stays set until cleared by software. The other status bits always read zero.
- R4: A write of 1 to a status bit clears it at that edge. A write of 0 leaves the bit unchanged. An event arriving at the same edge as its clearing write leaves the bit set.
- R5: `sci` is high exactly when `int_pin` is nonzero and (status AND enable) is nonzero in bits 0, 5, 8 or 10. It is combinational from the registers, so it drops in the cycle after the clearing write.
- R6: The timer counts up by one on every clock edge out of reset and wraps at 2^TMR_W. Writes to timer byte addresses are ignored.
- R7: When the timer's most-significant bit changes value, in either direction, status bit 0 becomes set at that edge.
- R8: `tmr_ovf` is high for exactly the cycle after a most-significant-bit change, and only if enable bit 0 was set and status bit 0 was clear in the cycle of the change.
- R9: All 16 bits of enable and control are writable and read back as written. Enable bits other than 0, 5, 8 and 10 never cause `sci`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | ADDR_W | Byte register address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` |
| evt_pwrbtn | input | 1 | Power button event |
| evt_rtc | input | 1 | RTC alarm event |
| evt_glbl | input | 1 | Global lock release event |
| int_pin | input | 8 | Configured interrupt pin value; zero suppresses SCI |
| sci | output | 1 | SCI interrupt level |
| tmr_ovf | output | 1 | One-cycle timer-overflow indication |

## Verification
On every cycle the embedded assertions check the following: the timer advances by exactly one; a status bit never drops without a write to its byte; an overflow pulse only follows an armed timer; and SCI stays low whenever no status bit is pending. The bench scenarios alone show the remaining cases. These are the exact byte map and readback, write-zero immunity, the event-versus-clear collision, suppression by a zero interrupt pin, ignored writes to the timer, and the overflow pulse going quiet once its status is already pending or its enable is off. A cycle-accurate reference model in the bench covers all of these by comparing every output on every cycle.

// File: rtl/pm_evt_pkg.sv
`timescale 1ns/1ps
package pm_evt_pkg;

    localparam int BIT_TMR    = 0;
    localparam int BIT_GLBL   = 5;
    localparam int BIT_PWRBTN = 8;
    localparam int BIT_RTC    = 10;

    localparam logic [15:0] SCI_SRC_MASK =
        16'((1 << BIT_TMR) | (1 << BIT_GLBL) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));

    localparam int OFS_STS = 0;
    localparam int OFS_EN  = 2;
    localparam int OFS_CTL = 4;
    localparam int OFS_TMR = 6;

    typedef struct packed {
        logic glbl;
        logic pwrbtn;
        logic rtc;
    } pm_evt_t;

    function automatic logic [15:0] evt_set_vec(pm_evt_t ev, logic tmr_flip);
        logic [15:0] v;
        v             = '0;
        v[BIT_TMR]    = tmr_flip;
        v[BIT_GLBL]   = ev.glbl;
        v[BIT_PWRBTN] = ev.pwrbtn;
        v[BIT_RTC]    = ev.rtc;
        return v;
    endfunction

    function automatic logic [15:0] put_byte(logic [15:0] cur, logic hi, logic [7:0] b);
        logic [15:0] v;
        v = cur;
        if (hi) v[15:8] = b;
        else    v[7:0]  = b;
        return v;
    endfunction

endpackage

// File: rtl/pm_timer.sv
`timescale 1ns/1ps
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    output logic [TMR_W-1:0] count,
    output logic             msb_flip
);
    localparam int LOW_W = TMR_W - 1;

    // the top bit changes at the next edge whenever all lower bits are ones
    assign msb_flip = &count[LOW_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    // R6: one step per cycle, wrapping at the width
    assert_tmr_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count == TMR_W'($past(count) + 1'b1));

endmodule

// File: rtl/pm_status_regs.sv
`timescale 1ns/1ps
module pm_status_regs
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int TMR_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  pm_evt_t           evt,
    input  logic              tmr_flip,
    input  logic [TMR_W-1:0]  tmr_count,
    output logic [15:0]       sts,
    output logic [15:0]       en,
    output logic [7:0]        rdata,
    output logic              tmr_ovf
);
    localparam int TMR_BYTES = (TMR_W + 7) / 8;
    localparam logic [ADDR_W-1:0] A_STS_LO = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_STS_HI = ADDR_W'(OFS_STS + 1);
    localparam logic [ADDR_W-1:0] A_EN_LO  = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_EN_HI  = ADDR_W'(OFS_EN + 1);
    localparam logic [ADDR_W-1:0] A_CTL_LO = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_CTL_HI = ADDR_W'(OFS_CTL + 1);

    logic [15:0] sts_q, en_q, ctl_q;
    logic [15:0] sts_d, en_d, ctl_d, clr_vec;
    logic        ovf_q;
    logic [8*TMR_BYTES-1:0] tmr_ext;

    always_comb begin
        clr_vec = '0;
        en_d    = en_q;
        ctl_d   = ctl_q;
        if (wr_en) begin
            if (addr == A_STS_LO) clr_vec[7:0]  = wdata;
            if (addr == A_STS_HI) clr_vec[15:8] = wdata;
            if (addr == A_EN_LO)  en_d  = put_byte(en_q, 1'b0, wdata);
            if (addr == A_EN_HI)  en_d  = put_byte(en_q, 1'b1, wdata);
            if (addr == A_CTL_LO) ctl_d = put_byte(ctl_q, 1'b0, wdata);
            if (addr == A_CTL_HI) ctl_d = put_byte(ctl_q, 1'b1, wdata);
        end
        // set dominates clear so that a simultaneous event is never lost
        sts_d = ((sts_q & ~clr_vec) | evt_set_vec(evt, tmr_flip)) & SCI_SRC_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
            ctl_q <= ctl_d;
            ovf_q <= tmr_flip & en_q[BIT_TMR] & ~sts_q[BIT_TMR];
        end
    end

    always_comb begin
        tmr_ext = '0;
        tmr_ext[TMR_W-1:0] = tmr_count;
        rdata = '0;
        case (addr)
            A_STS_LO: rdata = sts_q[7:0];
            A_STS_HI: rdata = sts_q[15:8];
            A_EN_LO:  rdata = en_q[7:0];
            A_EN_HI:  rdata = en_q[15:8];
            A_CTL_LO: rdata = ctl_q[7:0];
            A_CTL_HI: rdata = ctl_q[15:8];
            default: begin
                for (int b = 0; b < TMR_BYTES; b++) begin
                    if (addr == ADDR_W'(OFS_TMR + b)) rdata = tmr_ext[8*b +: 8];
                end
            end
        endcase
    end

    assign sts     = sts_q;
    assign en      = en_q;
    assign tmr_ovf = ovf_q;

    // R3: pending status survives every cycle without a write to the status bytes
    assert_sts_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == A_STS_LO || addr == A_STS_HI)) |=>
            ((sts_q & $past(sts_q)) == $past(sts_q)));

    // R8: an overflow pulse only follows an armed timer
    assert_ovf_armed_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> ($past(en_q[BIT_TMR]) && !$past(sts_q[BIT_TMR])));

endmodule

// File: rtl/pm_sci_gen.sv
`timescale 1ns/1ps
module pm_sci_gen
    import pm_evt_pkg::*;
(
    input  logic [15:0] sts,
    input  logic [15:0] en,
    input  logic [7:0]  int_pin,
    output logic        sci
);
    logic pending;
    logic pin_present;

    assign pending     = |(sts & en & SCI_SRC_MASK);
    assign pin_present = |int_pin;
    assign sci         = pending & pin_present;

endmodule

// File: rtl/pm_event_ctrl.sv
`timescale 1ns/1ps
module pm_event_ctrl
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int TMR_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              evt_pwrbtn,
    input  logic              evt_rtc,
    input  logic              evt_glbl,
    input  logic [7:0]        int_pin,
    output logic              sci,
    output logic              tmr_ovf
);
    logic [TMR_W-1:0] tmr_count;
    logic             tmr_flip;
    logic [15:0]      sts_w, en_w;
    pm_evt_t          evt_w;

    assign evt_w = '{glbl: evt_glbl, pwrbtn: evt_pwrbtn, rtc: evt_rtc};

    pm_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .count    (tmr_count),
        .msb_flip (tmr_flip)
    );

    pm_status_regs #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .evt       (evt_w),
        .tmr_flip  (tmr_flip),
        .tmr_count (tmr_count),
        .sts       (sts_w),
        .en        (en_w),
        .rdata     (reg_rdata),
        .tmr_ovf   (tmr_ovf)
    );

    pm_sci_gen u_sci (
        .sts     (sts_w),
        .en      (en_w),
        .int_pin (int_pin),
        .sci     (sci)
    );

    // R5: with nothing pending the interrupt line is quiet
    assert_sci_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (sts_w == '0) |-> !sci);

endmodule

// File: tb/test_pm_event_ctrl.sv
`timescale 1ns/1ps
module test_pm_event_ctrl;
    localparam int AW = 4;
    localparam int TW = 8;
    localparam int MASK = 16'h0521;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic evt_pwrbtn = 1'b0, evt_rtc = 1'b0, evt_glbl = 1'b0;
    logic [7:0] int_pin = 8'd0;
    logic sci, tmr_ovf;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // reference state
    int m_sts = 0, m_en = 0, m_ctl = 0, m_cnt = 0;
    bit m_ovf = 0;

    always #2.5 clk = ~clk;

    pm_event_ctrl #(.ADDR_W(AW), .TMR_W(TW)) i_pm_event_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .evt_glbl(evt_glbl),
        .int_pin(int_pin), .sci(sci), .tmr_ovf(tmr_ovf)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_sts = 0; m_en = 0; m_ctl = 0; m_cnt = 0; m_ovf = 0;
        end else begin
            int ns;
            bit flip;
            flip = ((m_cnt & ((1 << (TW-1)) - 1)) == ((1 << (TW-1)) - 1));
            ns = m_sts;
            if (reg_wr && reg_addr == 0) ns = ns & ~int'(reg_wdata);
            if (reg_wr && reg_addr == 1) ns = ns & ~(int'(reg_wdata) << 8);
            if (evt_pwrbtn) ns = ns | (1 << 8);
            if (evt_rtc)    ns = ns | (1 << 10);
            if (evt_glbl)   ns = ns | (1 << 5);
            if (flip)       ns = ns | 1;
            m_ovf = flip && ((m_en & 1) != 0) && ((m_sts & 1) == 0);
            if (reg_wr && reg_addr == 2) m_en  = (m_en  & 16'hFF00) | int'(reg_wdata);
            if (reg_wr && reg_addr == 3) m_en  = (m_en  & 16'h00FF) | (int'(reg_wdata) << 8);
            if (reg_wr && reg_addr == 4) m_ctl = (m_ctl & 16'hFF00) | int'(reg_wdata);
            if (reg_wr && reg_addr == 5) m_ctl = (m_ctl & 16'h00FF) | (int'(reg_wdata) << 8);
            m_sts = ns & MASK;
            m_cnt = (m_cnt + 1) % (1 << TW);
        end
    end

    function automatic int m_read(int a);
        case (a)
            0: return m_sts & 255;
            1: return (m_sts >> 8) & 255;
            2: return m_en & 255;
            3: return (m_en >> 8) & 255;
            4: return m_ctl & 255;
            5: return (m_ctl >> 8) & 255;
            6: return m_cnt & 255;
            default: return 0;
        endcase
    endfunction

    task automatic compare(input string tag);
        bit exp_sci;
        int exp_rd;
        exp_sci = (int_pin != 0) && ((m_sts & m_en & MASK) != 0);
        exp_rd  = m_read(int'(reg_addr));
        n_chk += 3;
        if (sci !== exp_sci) begin
            n_bad++;
            $display("FAIL %s sci actual=%b expected=%b", tag, sci, exp_sci);
        end
        if (tmr_ovf !== m_ovf) begin
            n_bad++;
            $display("FAIL %s tmr_ovf actual=%b expected=%b", tag, tmr_ovf, m_ovf);
        end
        if (int'(reg_rdata) !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata@%0d actual=%02h expected=%02h", tag, reg_addr, reg_rdata, exp_rd);
        end
    endtask

    task automatic cyc(input bit w, input int a, input int d,
                       input bit pb, input bit rt, input bit gl, input string tag);
        @(negedge clk);
        rst = 1'b0;
        reg_wr = w; reg_addr = AW'(a); reg_wdata = 8'(d);
        evt_pwrbtn = pb; evt_rtc = rt; evt_glbl = gl;
        #1;
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(0, k % 9, 0, 0, 0, 0, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 reset state, R2 full byte map readback
        for (int a = 0; a < 9; a++) cyc(0, a, 0, 0, 0, 0, "R1_R2");
        int_pin = 8'd1;
        // R9 enable/control storage and readback
        cyc(1, 2, 8'h20, 0, 0, 0, "R9");
        cyc(1, 3, 8'h05, 0, 0, 0, "R9");
        cyc(1, 4, 8'hA5, 0, 0, 0, "R9");
        cyc(1, 5, 8'h3C, 0, 0, 0, "R9");
        for (int a = 2; a < 6; a++) cyc(0, a, 0, 0, 0, 0, "R9");
        // R3 power button latch, R5 SCI raise
        cyc(0, 1, 0, 1, 0, 0, "R3");
        idle(3, "R3_R5");
        // R5 pin value zero suppresses SCI
        int_pin = 8'd0;
        cyc(0, 1, 0, 0, 0, 0, "R5");
        int_pin = 8'h7;
        cyc(0, 1, 0, 0, 0, 0, "R5");
        // R4 write zero ignored, write one clears
        cyc(1, 1, 8'h00, 0, 0, 0, "R4");
        cyc(0, 1, 0, 0, 0, 0, "R4");
        cyc(1, 1, 8'h01, 0, 0, 0, "R4");
        cyc(0, 1, 0, 0, 0, 0, "R4_R5");
        // R3 RTC and global lock, R4 set beats clear
        cyc(0, 0, 0, 0, 1, 1, "R3");
        cyc(1, 0, 8'h20, 0, 0, 1, "R4");
        cyc(0, 0, 0, 0, 0, 0, "R4");
        cyc(1, 1, 8'h04, 0, 0, 0, "R4");
        cyc(1, 0, 8'h20, 0, 0, 0, "R4");
        idle(2, "R5");
        // R9 enable bits outside the sources, with sources disabled
        cyc(1, 3, 8'hFA, 0, 0, 0, "R9");
        cyc(1, 2, 8'hDE, 0, 0, 0, "R9");
        cyc(0, 1, 0, 1, 0, 0, "R9");
        cyc(0, 3, 0, 0, 0, 0, "R9");
        cyc(1, 1, 8'h01, 0, 0, 0, "R9");
        // R6 writes to timer bytes ignored
        cyc(1, 6, 8'hFF, 0, 0, 0, "R6");
        cyc(1, 7, 8'h55, 0, 0, 0, "R6");
        cyc(0, 6, 0, 0, 0, 0, "R6");
        // R7 R8 armed timer: clear timer status, enable timer source
        cyc(1, 0, 8'h01, 0, 0, 0, "R7");
        cyc(1, 2, 8'h21, 0, 0, 0, "R8");
        cyc(1, 3, 8'h05, 0, 0, 0, "R8");
        idle(300, "R7_R8");
        // R8 pending status blocks re-arm; clear then disable
        cyc(1, 0, 8'h01, 0, 0, 0, "R8");
        cyc(1, 2, 8'h20, 0, 0, 0, "R8");
        idle(300, "R8");
        // R1 reset mid-run
        @(negedge clk); rst = 1'b1; reg_wr = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 9; a++) cyc(0, a, 0, 0, 0, 0, "R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule